// File: doc/BRIEF.md
# Shadow Video RAM Write Router

This block sits between a CPU memory bus and two memories: the main RAM and a separate 64K video RAM. The video RAM holds four 16K pages that mirror main RAM pages 4 to 7. A CPU write to one of those pages normally lands in both memories. Main RAM gets the write in the same cycle. The video RAM copy is posted into a one-entry address and data buffer, which drains whenever the display side grants a free write slot. The CPU therefore only stalls when a second video RAM write arrives while the first is still waiting for a slot.

A single 8-bit control register sits at one fully decoded I/O port address. Software uses it to:

- mask video RAM writes for each screen region;
- block main RAM writes to the mirrored pages;
- take CPU reads of those pages from the video RAM instead of main RAM;
- flag double horizontal resolution to the display;
- hand the video RAM write port to an external 1-bit-per-pixel capture source.

A read of video RAM whose address matches a write still waiting in the buffer returns the buffered byte. Resolving which page the CPU addresses for pages 0 to 3, and turning pixels into a serial stream, belong to other blocks.

Top module: `vram_shadow_router`

## Requirements
- R1: The control register answers only the full 16-bit port address 0xBF7E. It resets to 0x00, an I/O write there loads cpu_wdata, and an I/O read there returns its value. Writes to any other port (for example 0xBF7F or 0x3F7E) leave it unchanged.
- R2: A CPU memory write to any page drives mram_we in the cycle it is accepted, with mram_addr = {page, offset}. Control bit 4 suppresses main RAM writes for pages 4 to 7 only. mram_we stays low while cpu_wait is high.
- R3: A write to page p in 4..7 at offset o appears on the video RAM write port with address {p[1:0], o} and the same data, in the first cycle after acceptance in which disp_slot_free is high. Writes to pages 0 to 3 never reach the video RAM.
- R4: Control bits mask video RAM writes by region:
  - bit 0 blocks page 5 offsets 0x0000-0x1FFF;
  - bit 1 blocks page 7 offsets 0x0000-0x1FFF;
  - bit 2 blocks offsets 0x2000-0x3FFF of pages 5 and 7;
  - bit 3 blocks all of pages 4 and 6.
  
  A masked write never reaches the video RAM.
- R5: cpu_wait rises when a video RAM write arrives while the buffer holds an unfinished write and no slot is free. It stays high until a slot drains the buffer, and the held write is then accepted in that cycle.
- R6: A video RAM write meets no wait when the buffer is empty, or when the buffer drains in the same cycle.
- R7: With control bit 5 set, CPU reads of pages 4 to 7 return video RAM data from address {page[1:0], offset}. Otherwise, and always for pages 0 to 3, they return main RAM data.
- R8: A read steered to the video RAM whose address matches the pending buffered write returns the buffered byte.
- R9: With control bit 7 set:
  - the video RAM write port carries ext_px_valid, ext_px_addr and ext_px_data;
  - CPU writes still reach main RAM but are never queued for the video RAM, even after bit 7 is cleared again.
- R10: dbl_hres follows control bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_port | input | 16 | I/O port address |
| cpu_wdata | input | 8 | CPU write data (I/O and memory) |
| mem_wr | input | 1 | Memory write request, held while cpu_wait |
| mem_rd | input | 1 | Memory read request |
| mem_page | input | 3 | Resolved 16K page of the access |
| mem_off | input | 14 | Offset inside the page |
| cpu_rdata | output | 8 | Read data to the CPU |
| cpu_wait | output | 1 | Stall request to the CPU |
| mram_we | output | 1 | Main RAM write enable |
| mram_addr | output | 17 | Main RAM address |
| mram_wdata | output | 8 | Main RAM write data |
| mram_rdata | input | 8 | Main RAM read data |
| vram_we | output | 1 | Video RAM write enable |
| vram_waddr | output | 16 | Video RAM write address |
| vram_wdata | output | 8 | Video RAM write data |
| vram_raddr | output | 16 | Video RAM CPU read address |
| vram_rdata | input | 8 | Video RAM CPU read data |
| disp_slot_free | input | 1 | Display grants the write port this cycle |
| ext_px_valid | input | 1 | External pixel source write strobe |
| ext_px_addr | input | 16 | External pixel source address |
| ext_px_data | input | 8 | External pixel source data |
| dbl_hres | output | 1 | Double horizontal resolution select |

## Verification
The bench builds the block with its default parameters: 8-bit data, 14-bit offsets, 3-bit page numbers and the control port at 0xBF7E. These widths put both halves of every mirrored page, and the boundary offsets 0x0000, 0x1FFF/0x2000 and 0x3FFF, within reach of direct stimulus. Because the bench drives disp_slot_free itself, it can hold the slot off to fill the buffer, force a stall, and read back a pending write.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

    // Control register layout; bit positions are software-visible.
    typedef struct packed {
        logic ext_owner;   // bit 7: external pixel source owns video RAM writes
        logic dbl_hres;    // bit 6: double horizontal resolution
        logic rd_vram;     // bit 5: CPU reads of mirrored pages come from video RAM
        logic main_lock;   // bit 4: block main RAM writes to mirrored pages
        logic lock_even;   // bit 3: block video RAM pages 4 and 6
        logic lock_hi;     // bit 2: block upper 8K of pages 5 and 7
        logic lock_p7_lo;  // bit 1: block lower 8K of page 7
        logic lock_p5_lo;  // bit 0: block lower 8K of page 5
    } ctl_t;

endpackage

// File: rtl/vsr_ctl_reg.sv
module vsr_ctl_reg
    import vsr_pkg::*;
#(
    parameter int                PORT_W    = 16,
    parameter logic [PORT_W-1:0] PORT_ADDR = 16'hBF7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [PORT_W-1:0] io_port,
    input  logic [7:0]        wdata,
    output ctl_t              ctl_q,
    output logic              hit
);

    ctl_t ctl_d;

    always_comb begin
        hit   = (io_port == PORT_ADDR);
        ctl_d = ctl_q;
        if (io_wr && hit) begin
            ctl_d = ctl_t'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/vsr_region_dec.sv
module vsr_region_dec
    import vsr_pkg::*;
#(
    parameter int PAGE_W = 3
) (
    input  logic [PAGE_W-1:0] page,
    input  logic              off_hi,
    input  ctl_t              ctl,
    output logic              shadow,
    output logic              vram_wr_en,
    output logic              mram_wr_en
);

    localparam int UPPER_W = PAGE_W - 2;

    always_comb begin
        // Pages 4..7: upper page bits equal one.
        shadow     = (page[PAGE_W-1:2] == UPPER_W'(1));
        vram_wr_en = 1'b0;
        if (shadow && !ctl.ext_owner) begin
            case (page[1:0])
                2'd1:    vram_wr_en = off_hi ? !ctl.lock_hi : !ctl.lock_p5_lo;
                2'd3:    vram_wr_en = off_hi ? !ctl.lock_hi : !ctl.lock_p7_lo;
                default: vram_wr_en = !ctl.lock_even;
            endcase
        end
        mram_wr_en = !(shadow && ctl.main_lock);
    end

endmodule

// File: rtl/vsr_post_buf.sv
module vsr_post_buf #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          slot_ok,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic          drain
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } pb_t;

    pb_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        drain = st_q.valid && slot_ok;
        if (load) begin
            st_d.valid = 1'b1;
            st_d.addr  = ld_addr;
            st_d.data  = ld_data;
        end else if (drain) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign addr  = st_q.addr;
    assign data  = st_q.data;

endmodule

// File: rtl/vram_shadow_router.sv
module vram_shadow_router
    import vsr_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                OFF_W    = 14,
    parameter int                PAGE_W   = 3,
    parameter int                PORT_W   = 16,
    parameter logic [PORT_W-1:0] CTL_PORT = 16'hBF7E,
    localparam int               VRAM_AW  = OFF_W + 2,
    localparam int               MRAM_AW  = OFF_W + PAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [PORT_W-1:0]  io_port,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               mem_wr,
    input  logic               mem_rd,
    input  logic [PAGE_W-1:0]  mem_page,
    input  logic [OFF_W-1:0]   mem_off,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_wait,
    output logic               mram_we,
    output logic [MRAM_AW-1:0] mram_addr,
    output logic [DATA_W-1:0]  mram_wdata,
    input  logic [DATA_W-1:0]  mram_rdata,
    output logic               vram_we,
    output logic [VRAM_AW-1:0] vram_waddr,
    output logic [DATA_W-1:0]  vram_wdata,
    output logic [VRAM_AW-1:0] vram_raddr,
    input  logic [DATA_W-1:0]  vram_rdata,
    input  logic               disp_slot_free,
    input  logic               ext_px_valid,
    input  logic [VRAM_AW-1:0] ext_px_addr,
    input  logic [DATA_W-1:0]  ext_px_data,
    output logic               dbl_hres
);

    ctl_t               ctl_q;
    logic               ctl_hit;
    logic               shadow;
    logic               vram_wr_en;
    logic               mram_wr_en;
    logic               buf_valid;
    logic               buf_drain;
    logic               buf_load;
    logic               slot_ok;
    logic [VRAM_AW-1:0] buf_addr;
    logic [DATA_W-1:0]  buf_data;
    logic [VRAM_AW-1:0] vaddr;

    vsr_ctl_reg #(
        .PORT_W   (PORT_W),
        .PORT_ADDR(CTL_PORT)
    ) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .io_wr  (io_wr),
        .io_port(io_port),
        .wdata  (cpu_wdata[7:0]),
        .ctl_q  (ctl_q),
        .hit    (ctl_hit)
    );

    vsr_region_dec #(
        .PAGE_W(PAGE_W)
    ) u_dec (
        .page      (mem_page),
        .off_hi    (mem_off[OFF_W-1]),
        .ctl       (ctl_q),
        .shadow    (shadow),
        .vram_wr_en(vram_wr_en),
        .mram_wr_en(mram_wr_en)
    );

    vsr_post_buf #(
        .AW(VRAM_AW),
        .DW(DATA_W)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (buf_load),
        .ld_addr(vaddr),
        .ld_data(cpu_wdata),
        .slot_ok(slot_ok),
        .valid  (buf_valid),
        .addr   (buf_addr),
        .data   (buf_data),
        .drain  (buf_drain)
    );

    // Buffer drain and CPU handshake
    always_comb begin
        vaddr    = {mem_page[1:0], mem_off};
        slot_ok  = disp_slot_free && !ctl_q.ext_owner;
        buf_load = mem_wr && vram_wr_en && (!buf_valid || buf_drain);
        cpu_wait = mem_wr && vram_wr_en && buf_valid && !buf_drain;
    end

    // Main RAM side
    always_comb begin
        mram_addr  = {mem_page, mem_off};
        mram_wdata = cpu_wdata;
        mram_we    = mem_wr && mram_wr_en && !cpu_wait;
    end

    // Video RAM write port: external source or posted CPU write
    always_comb begin
        if (ctl_q.ext_owner) begin
            vram_we    = ext_px_valid;
            vram_waddr = ext_px_addr;
            vram_wdata = ext_px_data;
        end else begin
            vram_we    = buf_drain;
            vram_waddr = buf_addr;
            vram_wdata = buf_data;
        end
    end

    // CPU read data
    always_comb begin
        vram_raddr = vaddr;
        cpu_rdata  = '0;
        if (io_rd && ctl_hit) begin
            cpu_rdata = DATA_W'(ctl_q);
        end else if (mem_rd) begin
            if (shadow && ctl_q.rd_vram) begin
                cpu_rdata = (buf_valid && (buf_addr == vaddr)) ? buf_data : vram_rdata;
            end else begin
                cpu_rdata = mram_rdata;
            end
        end
    end

    assign dbl_hres = ctl_q.dbl_hres;

endmodule

// File: rtl/vsr_checker.sv
module vsr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       io_wr,
    input logic       ctl_hit,
    input logic [7:0] wdata,
    input logic [7:0] ctl_q,
    input logic       mem_wr,
    input logic       shadow,
    input logic       disp_slot_free,
    input logic       ext_px_valid,
    input logic       cpu_wait,
    input logic       mram_we,
    input logic       vram_we,
    input logic       buf_valid,
    input logic       dbl_hres
);

    assert_ctl_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && ctl_hit) |=> (ctl_q == $past(wdata)));

    assert_ctl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && ctl_hit) |=> $stable(ctl_q));

    assert_main_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[4] && shadow) |-> !mram_we);

    assert_no_main_when_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |-> !mram_we);

    assert_drain_needs_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_we && !ctl_q[7]) |-> disp_slot_free);

    assert_wait_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |-> (mem_wr && shadow && buf_valid));

    assert_buf_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && !disp_slot_free) |=> buf_valid);

    assert_ext_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[7] |-> (vram_we == ext_px_valid));

    assert_hres_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_hres == ctl_q[6]);

endmodule

bind vram_shadow_router vsr_checker u_vsr_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_wr         (io_wr),
    .ctl_hit       (ctl_hit),
    .wdata         (cpu_wdata[7:0]),
    .ctl_q         (ctl_q),
    .mem_wr        (mem_wr),
    .shadow        (shadow),
    .disp_slot_free(disp_slot_free),
    .ext_px_valid  (ext_px_valid),
    .cpu_wait      (cpu_wait),
    .mram_we       (mram_we),
    .vram_we       (vram_we),
    .buf_valid     (buf_valid),
    .dbl_hres      (dbl_hres)
);

// File: tb/vram_shadow_router_bench.sv
`timescale 1ns/1ps
module vram_shadow_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 0, io_rd = 0, mem_wr = 0, mem_rd = 0;
    logic [15:0] io_port = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [2:0]  mem_page = '0;
    logic [13:0] mem_off = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_wait;
    logic        mram_we;
    logic [16:0] mram_addr;
    logic [7:0]  mram_wdata, mram_rdata;
    logic        vram_we;
    logic [15:0] vram_waddr, vram_raddr;
    logic [7:0]  vram_wdata, vram_rdata;
    logic        disp_slot_free = 1'b0;
    logic        ext_px_valid = 1'b0;
    logic [15:0] ext_px_addr = '0;
    logic [7:0]  ext_px_data = '0;
    logic        dbl_hres;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [23:0] exp_q[$];

    always #10 clk = ~clk;

    function automatic logic [7:0] vfn(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] mfn(input logic [16:0] a);
        return a[7:0] + a[16:9] + 8'h11;
    endfunction

    assign vram_rdata = vfn(vram_raddr);
    assign mram_rdata = mfn(mram_addr);

    vram_shadow_router u_vram_shadow_router (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every video RAM write must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && vram_we) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3/R4: actual write %h:%h expected none", vram_waddr, vram_wdata);
            end else begin
                logic [23:0] it;
                it = exp_q.pop_front();
                if ({vram_waddr, vram_wdata} !== it) begin
                    n_fail++;
                    $display("FAIL R3: actual write %h expected %h", {vram_waddr, vram_wdata}, it);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_idle();
        io_wr = 0; io_rd = 0; mem_wr = 0; mem_rd = 0;
    endtask

    task automatic put_wr(input logic [2:0] p, input logic [13:0] o, input logic [7:0] d);
        mem_wr = 1; mem_page = p; mem_off = o; cpu_wdata = d;
    endtask

    task automatic expect_v(input logic [15:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic io_write(input logic [15:0] port, input logic [7:0] d);
        step(); io_wr = 1; io_port = port; cpu_wdata = d;
        step(); bus_idle();
    endtask

    task automatic io_read(input logic [15:0] port, output logic [7:0] d);
        step(); io_rd = 1; io_port = port;
        @(negedge clk); d = cpu_rdata;
        step(); bus_idle();
    endtask

    task automatic cpu_write(input logic [2:0] p, input logic [13:0] o, input logic [7:0] d, output logic mw);
        step(); put_wr(p, o, d);
        @(negedge clk);
        while (cpu_wait) @(negedge clk);
        mw = mram_we;
        step(); bus_idle();
    endtask

    task automatic cpu_read(input logic [2:0] p, input logic [13:0] o, output logic [7:0] d);
        step(); mem_rd = 1; mem_page = p; mem_off = o;
        @(negedge clk); d = cpu_rdata;
        step(); bus_idle();
    endtask

    task automatic settle(input string tag);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic       mw;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset value and readback; R10 reset value
        io_read(16'hBF7E, rd);
        chk(rd == 8'h00, "R1 reset value", rd, 8'h00);
        chk(dbl_hres == 1'b0, "R10 reset", dbl_hres, 0);
        chk(cpu_wait == 1'b0, "R6 idle wait", cpu_wait, 0);
        io_write(16'hBF7E, 8'h5A);
        io_read(16'hBF7E, rd);
        chk(rd == 8'h5A, "R1 readback", rd, 8'h5A);
        io_write(16'hBF7F, 8'hFF);
        io_write(16'h3F7E, 8'hFF);
        io_read(16'hBF7E, rd);
        chk(rd == 8'h5A, "R1 partial decode ignored", rd, 8'h5A);

        // R10 double resolution flag
        io_write(16'hBF7E, 8'h40);
        @(negedge clk);
        chk(dbl_hres == 1'b1, "R10 set", dbl_hres, 1);
        io_write(16'hBF7E, 8'h00);
        @(negedge clk);
        chk(dbl_hres == 1'b0, "R10 clear", dbl_hres, 0);

        // R2/R3 basic mirroring with slots free
        disp_slot_free = 1'b1;
        cpu_write(3'd2, 14'h0123, 8'hB2, mw);
        chk(mw == 1'b1, "R2 low page main write", mw, 1);
        expect_v(16'h4123, 8'hA1);
        cpu_write(3'd5, 14'h0123, 8'hA1, mw);
        chk(mw == 1'b1, "R2 mirrored main write", mw, 1);
        settle("R3 mirror drained");

        // R5/R6 stall when buffer full and no slot
        disp_slot_free = 1'b0;
        expect_v(16'h4100, 8'h11);
        expect_v(16'h4101, 8'h22);
        step(); put_wr(3'd5, 14'h0100, 8'h11);
        @(negedge clk);
        chk(cpu_wait == 1'b0, "R6 empty buffer no wait", cpu_wait, 0);
        chk(mram_we == 1'b1, "R2 first write main", mram_we, 1);
        step(); put_wr(3'd5, 14'h0101, 8'h22);
        @(negedge clk);
        chk(cpu_wait == 1'b1, "R5 full buffer wait", cpu_wait, 1);
        chk(mram_we == 1'b0, "R2 no main write while waiting", mram_we, 0);
        step();
        @(negedge clk);
        chk(cpu_wait == 1'b1, "R5 wait held", cpu_wait, 1);
        step(); disp_slot_free = 1'b1;
        @(negedge clk);
        chk(cpu_wait == 1'b0, "R6 drain same cycle releases", cpu_wait, 0);
        chk(mram_we == 1'b1, "R2 held write reaches main", mram_we, 1);
        step(); bus_idle();
        settle("R5 both writes drained in order");

        // R4 region masks
        io_write(16'hBF7E, 8'h01);
        cpu_write(3'd5, 14'h0010, 8'h31, mw);
        expect_v(16'h6010, 8'h32);
        cpu_write(3'd5, 14'h2010, 8'h32, mw);
        expect_v(16'hC010, 8'h33);
        cpu_write(3'd7, 14'h0010, 8'h33, mw);
        settle("R4 bit0 mask");
        io_write(16'hBF7E, 8'h02);
        cpu_write(3'd7, 14'h0020, 8'h41, mw);
        expect_v(16'h4020, 8'h42);
        cpu_write(3'd5, 14'h0020, 8'h42, mw);
        settle("R4 bit1 mask");
        io_write(16'hBF7E, 8'h04);
        cpu_write(3'd5, 14'h2030, 8'h51, mw);
        cpu_write(3'd7, 14'h3FFF, 8'h52, mw);
        expect_v(16'hC030, 8'h53);
        cpu_write(3'd7, 14'h0030, 8'h53, mw);
        settle("R4 bit2 mask");
        io_write(16'hBF7E, 8'h08);
        cpu_write(3'd4, 14'h0040, 8'h61, mw);
        cpu_write(3'd6, 14'h1000, 8'h62, mw);
        expect_v(16'h4040, 8'h63);
        cpu_write(3'd5, 14'h0040, 8'h63, mw);
        settle("R4 bit3 mask");

        // R2 main lock, R3 low pages never mirrored
        io_write(16'hBF7E, 8'h10);
        expect_v(16'h8050, 8'h71);
        cpu_write(3'd6, 14'h0050, 8'h71, mw);
        chk(mw == 1'b0, "R2 main lock blocks page 6", mw, 0);
        cpu_write(3'd1, 14'h0050, 8'h72, mw);
        chk(mw == 1'b1, "R2 main lock spares page 1", mw, 1);
        settle("R3 page 1 not mirrored");

        // R7 read steering
        io_write(16'hBF7E, 8'h00);
        cpu_read(3'd6, 14'h0778, rd);
        chk(rd == mfn({3'd6, 14'h0778}), "R7 main read", rd, mfn({3'd6, 14'h0778}));
        io_write(16'hBF7E, 8'h20);
        cpu_read(3'd6, 14'h0778, rd);
        chk(rd == vfn(16'h8778), "R7 video read", rd, vfn(16'h8778));
        cpu_read(3'd2, 14'h0778, rd);
        chk(rd == mfn({3'd2, 14'h0778}), "R7 low page stays main", rd, mfn({3'd2, 14'h0778}));

        // R8 forwarding from pending buffer
        disp_slot_free = 1'b0;
        expect_v(16'h0777, 8'h3C);
        cpu_write(3'd4, 14'h0777, 8'h3C, mw);
        cpu_read(3'd4, 14'h0777, rd);
        chk(rd == 8'h3C, "R8 forwarded byte", rd, 8'h3C);
        cpu_read(3'd4, 14'h0778, rd);
        chk(rd == vfn(16'h0778), "R8 miss reads memory", rd, vfn(16'h0778));
        disp_slot_free = 1'b1;
        settle("R8 buffered write drained");

        // R9 external source owns video RAM writes
        io_write(16'hBF7E, 8'h80);
        expect_v(16'h1234, 8'h99);
        step(); ext_px_valid = 1; ext_px_addr = 16'h1234; ext_px_data = 8'h99;
        @(negedge clk);
        chk(vram_we == 1'b1, "R9 external write port", vram_we, 1);
        step(); ext_px_valid = 0;
        cpu_write(3'd5, 14'h0055, 8'h77, mw);
        chk(mw == 1'b1, "R9 main still written", mw, 1);
        settle("R9 cpu write not mirrored");
        io_write(16'hBF7E, 8'h00);
        settle("R9 nothing queued after release");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule